// File: doc/BRIEF.md
# Serial Byte-Memory Target on a Two-Wire Bus

This block sits on an I2C-style two-wire bus as a target and behaves like a small serial memory. It follows the clock line (SCL) and the data line (SDA) through two-flop synchronisers running on the system clock. It detects bus start and stop events and receives a control byte that carries a device code, a block select and a direction flag. Storage is organised as `BLOCKS` blocks of 256 bytes. An internal word pointer selects the byte inside the current block.

A write transfer has three bytes: the control byte with the write flag, a word address, and one data byte. To read from a chosen address, the master first sends a write-flagged control byte and the address, then a repeated start, then the control byte again with the read flag. The block then returns bytes MSB first. A read-flagged control byte on its own returns data from the current pointer position. The block never drives SDA high. `sda_oe` pulls the line low and is otherwise released. The bus has no stream handshake, so the bus pins are plain control pins with no back-pressure: each bit is taken when SCL rises.

Top module: `twowire_mem_target`

## Requirements
- R1: After reset `sda_oe` is 0 and every stored byte reads as 0x00.
- R2: SDA falling while SCL is high (start) begins a new transfer from any state, including a repeated start in mid-transfer. SDA rising while SCL is high (stop) returns the block to idle with `sda_oe` at 0.
- R3: The control byte is taken MSB first: bits [7:4] are the device code (default 4'b1010), bits [3:1] are the block select, and bit [0] is the direction (0 write, 1 read). If the code matches, the block acknowledges by holding SDA low during the ninth SCL high phase.
- R4: After a control byte with a different device code, the block gives no acknowledge. It keeps `sda_oe` at 0 and ignores all following bytes until the next start or stop, so nothing is stored.
- R5: In a write, the block acknowledges the address byte and then one data byte. It stores the data byte at that address in the selected block.
- R6: A write-flagged control byte plus an address, followed by a repeated start and a read-flagged control byte, returns the byte stored at that address, MSB first.
- R7: The word pointer steps by one after each byte stored or sent, wrapping from 0xFF to 0x00 inside the same block. A master ACK after a read byte makes the block send the next byte, and a read with no address phase starts at the pointer.
- R8: A master NACK after a read byte makes the block release SDA and ignore the bus until the next start or stop.
- R9: A second data byte in the same write transfer gets no acknowledge and is not stored.
- R10: The block select is taken modulo `BLOCKS`. Blocks are independent, so the same address in two blocks holds two values.
- R11: The block changes `sda_oe` only while SCL is low. The level it drives stays stable through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
An SCL edge or an SDA event at the pins reaches the bit engine after the two synchroniser flops. `sda_oe` then changes on the third system clock edge after the pin change, so an acknowledge or a data bit is in place within three cycles of SCL falling. The bench holds every bus phase for ten system clocks. It samples SDA four clocks after SCL rises and again just before SCL falls, so each sample falls well after the three-cycle latency has settled. The two samples in each high phase must agree, which is how drive stability is checked.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } twm_state_e;

  localparam int BYTE_W   = 8;
  localparam int SLOT_ACK = 8;
  localparam int SLOT_END = 9;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/twm_store.sv
module twm_store #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5: a write strobe always carries a defined address
  a_r5_write_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(waddr));
endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         BLK_BITS = 1,
  localparam int        AW       = BLK_BITS + BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] raddr,
  input  logic [7:0]    rdata,
  output logic          sda_oe
);
  localparam logic [3:0] C_ACK = 4'(SLOT_ACK);
  localparam logic [3:0] C_END = 4'(SLOT_END);

  twm_state_e            state;
  logic [3:0]            cnt;
  logic [7:0]            sh;
  logic [7:0]            tx;
  logic [7:0]            ptr;
  logic [BLK_BITS-1:0]   blk;
  logic                  rw;
  logic                  mack;
  logic                  oe;
  logic                  code_ok;
  logic                  active;

  assign code_ok = (sh[7:4] == DEV_CODE);
  assign active  = (state == ST_CTRL) || (state == ST_ADDR) ||
                   (state == ST_WDATA) || (state == ST_RDATA);
  assign we      = (state == ST_WDATA) && scl_fall && (cnt == C_ACK) &&
                   !start_det && !stop_det;
  assign waddr   = {blk, ptr};
  assign raddr   = {blk, ptr};
  assign wdata   = sh;
  assign sda_oe  = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      blk   <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      oe    <= 1'b0;
    end else if (start_det) begin
      state <= ST_CTRL;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt < C_ACK) sh <= {sh[6:0], sda_s};
        if (cnt == C_ACK) mack <= !sda_s;
        if (cnt < C_END) cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == C_ACK) begin
          unique case (state)
            ST_CTRL: begin
              if (code_ok) begin
                blk <= sh[BLK_BITS:1];
                rw  <= sh[0];
                oe  <= 1'b1;
              end else begin
                state <= ST_WAIT;
              end
            end
            ST_ADDR: begin
              ptr <= sh;
              oe  <= 1'b1;
            end
            ST_WDATA: begin
              ptr <= ptr + 8'd1;
              oe  <= 1'b1;
            end
            default: begin
              ptr <= ptr + 8'd1;
              oe  <= 1'b0;
            end
          endcase
        end else if (cnt == C_END) begin
          cnt <= '0;
          unique case (state)
            ST_CTRL: begin
              tx    <= rdata;
              oe    <= rw ? !rdata[7] : 1'b0;
              state <= rw ? ST_RDATA : ST_ADDR;
            end
            ST_ADDR: begin
              oe    <= 1'b0;
              state <= ST_WDATA;
            end
            ST_WDATA: begin
              oe    <= 1'b0;
              state <= ST_WAIT;
            end
            default: begin
              if (mack) begin
                tx <= rdata;
                oe <= !rdata[7];
              end else begin
                oe    <= 1'b0;
                state <= ST_WAIT;
              end
            end
          endcase
        end else if ((state == ST_RDATA) && (cnt != 4'd0)) begin
          oe <= !tx[6];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  // R2: a start always lands in control-byte reception with the line released
  a_r2_start_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_CTRL) && !sda_oe);

  // R2: a stop frees the bus and releases the line
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE) && !sda_oe);

  // R4, R8: while ignoring the bus the line stays released
  a_r4_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R11: the pull-down is only applied while the clock line is low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R7: each stored byte advances the pointer by one, modulo 256
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == $past(ptr) + 8'd1);
endmodule

// File: rtl/twowire_mem_target.sv
module twowire_mem_target #(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         BLOCKS      = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int BLK_BITS = (BLOCKS > 2) ? $clog2(BLOCKS) : 1;
  localparam int AW       = BLK_BITS + 8;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_engine #(.DEV_CODE(DEV_CODE), .BLK_BITS(BLK_BITS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .raddr     (raddr),
    .rdata     (rdata),
    .sda_oe    (sda_oe)
  );

  twm_store #(.AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );
endmodule

// File: tb/sim_twowire_mem_target.sv
`timescale 1ns/1ps
module sim_twowire_mem_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   checks = 0;
  int   errors = 0;
  int   oe_hits = 0;
  int   r11_bad = 0;
  bit   done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  always @(negedge clk) if (sda_oe) oe_hits++;

  twowire_mem_target u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl),
    .sda_in (sda_line),
    .sda_oe (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !sda_line;
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic a;
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(4);
      a = sda_line; tick(Q - 4);
      if (a !== sda_line) r11_bad++;
      b = {b[6:0], sda_line};
      scl = 1'b0;
    end
    tick(Q);
    sda_m = !give_ack; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] blk, input bit rd);
    return {4'b1010, blk, rd};
  endfunction

  task automatic do_write(input logic [2:0] blk, input logic [7:0] addr, input logic [7:0] d);
    bit a0, a1, a2;
    bus_start();
    send_byte(ctrl(blk, 1'b0), a0);
    send_byte(addr, a1);
    send_byte(d, a2);
    bus_stop();
    chk(a0, "R3 control ack", a0, 1);
    chk(a1 && a2, "R5 address/data ack", {a1, a2}, 3);
    tick(Q);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  task automatic do_read(input logic [2:0] blk, input logic [7:0] addr,
                         input logic [7:0] exp, input string req);
    bit a0, a1, a2;
    logic [7:0] d;
    bus_start();
    send_byte(ctrl(blk, 1'b0), a0);
    send_byte(addr, a1);
    bus_start();
    send_byte(ctrl(blk, 1'b1), a2);
    recv_byte(1'b0, d);
    bus_stop();
    chk(a0 && a1 && a2, "R2 repeated start acks", {a0, a1, a2}, 7);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset();
    tick(3);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1; tick(5);
    do_read(3'd0, 8'h33, 8'h00, "R1 cleared store");
  endtask

  task automatic t_write_read();
    do_write(3'd0, 8'h10, 8'hA5);
    do_write(3'd0, 8'h11, 8'h3C);
    do_read(3'd0, 8'h10, 8'hA5, "R6 random read 0x10");
    do_read(3'd0, 8'h11, 8'h3C, "R6 random read 0x11");
  endtask

  task automatic t_sequential();
    bit a0, a1, a2;
    logic [7:0] d0, d1;
    bus_start();
    send_byte(ctrl(3'd0, 1'b0), a0);
    send_byte(8'h10, a1);
    bus_start();
    send_byte(ctrl(3'd0, 1'b1), a2);
    recv_byte(1'b1, d0);
    recv_byte(1'b0, d1);
    bus_stop();
    chk(d0 == 8'hA5, "R7 first sequential byte", d0, 8'hA5);
    chk(d1 == 8'h3C, "R7 pointer step on ACK", d1, 8'h3C);
  endtask

  task automatic t_wrap();
    bit a0;
    logic [7:0] d;
    do_write(3'd0, 8'h00, 8'hC3);
    do_write(3'd0, 8'hFF, 8'h5A);
    bus_start();
    send_byte(ctrl(3'd0, 1'b1), a0);
    recv_byte(1'b0, d);
    bus_stop();
    chk(a0, "R7 current read ack", a0, 1);
    chk(d == 8'hC3, "R7 wrap 0xFF to 0x00", d, 8'hC3);
  endtask

  task automatic t_blocks();
    do_write(3'd1, 8'h10, 8'h96);
    do_read(3'd1, 8'h10, 8'h96, "R10 block 1 value");
    do_read(3'd0, 8'h10, 8'hA5, "R10 block 0 untouched");
    do_read(3'd3, 8'h10, 8'h96, "R10 select modulo blocks");
  endtask

  task automatic t_mismatch();
    bit a0, a1, a2;
    bus_start();
    oe_hits = 0;
    send_byte(8'b0110_0000, a0);
    send_byte(8'h10, a1);
    send_byte(8'h00, a2);
    chk(!a0 && !a1 && !a2, "R4 no ack on foreign code", {a0, a1, a2}, 0);
    chk(oe_hits == 0, "R4 line never pulled", oe_hits, 0);
    bus_stop();
    do_read(3'd0, 8'h10, 8'hA5, "R4 nothing stored");
  endtask

  task automatic t_extra_byte();
    bit a0, a1, a2, a3;
    bus_start();
    send_byte(ctrl(3'd0, 1'b0), a0);
    send_byte(8'h20, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    bus_stop();
    chk(a0 && a1 && a2, "R5 single write acks", {a0, a1, a2}, 7);
    chk(!a3, "R9 second data byte not acked", a3, 0);
    do_read(3'd0, 8'h20, 8'h11, "R5 stored data");
    do_read(3'd0, 8'h21, 8'h00, "R9 second byte not stored");
  endtask

  task automatic t_nack();
    bit a0, a1, a2, a3;
    logic [7:0] d;
    bus_start();
    send_byte(ctrl(3'd1, 1'b0), a0);
    send_byte(8'h10, a1);
    bus_start();
    send_byte(ctrl(3'd1, 1'b1), a2);
    recv_byte(1'b0, d);
    oe_hits = 0;
    send_byte(8'hFF, a3);
    chk(d == 8'h96, "R8 data before NACK", d, 8'h96);
    chk(oe_hits == 0 && !a3, "R8 released after NACK", oe_hits, 0);
    bus_stop();
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_sequential();
    t_wrap();
    t_blocks();
    t_mismatch();
    t_extra_byte();
    t_nack();
    chk(r11_bad == 0, "R11 stable during SCL high", r11_bad, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule